// File: doc/BRIEF.md
# Packed int32 to FP64 converter

This unit turns a vector of signed 32-bit integers into IEEE-754 double-precision values, one 64-bit result lane for each source element. A two-bit form input picks one of three variants. The first is a 128-bit legacy form that keeps the old upper half of the destination. The second is a 128-bit extended form that clears the upper half. The third is a 256-bit form that converts all four elements. Every signed 32-bit integer fits exactly in double precision, so the datapath has no rounding and never raises a floating-point exception.

The extended forms also carry a 4-bit spare register-specifier field, and that field must read all ones. Any other value marks the operation as an undefined opcode and suppresses the write. The result, the write-enable and the undefined-opcode flag are registered together. They appear one clock after the input is accepted and are qualified by a valid output. The unit does not decode instructions, fetch operands, store registers or raise traps.

Top module: `pk_i2f64_conv`

## Requirements
- R1: Result lane i (out_data bits 64*i+63..64*i) is the exact double-precision value of the signed integer in in_src bits 32*i+31..32*i: the sign is bit 63, the biased exponent (bias 1023) is in bits 62..52, and the fraction without its hidden bit is in bits 51..0.
- R2: In the two 128-bit forms (in_form 2'b00 and 2'b01), only lanes 0 and 1 are converted, from in_src bits 63..0, and in_src bits 127..64 have no effect on the output.
- R3: In the 256-bit form (in_form 2'b10), all four lanes are converted, from the full 128-bit source.
- R4: In the legacy 128-bit form (in_form 2'b00), out_data bits 255..128 equal in_old_dst bits 255..128 of the same operation. The spare field in_spec is not checked in this form, so out_ud is 0 and out_wen is 1.
- R5: In the extended 128-bit form (in_form 2'b01), out_data bits 255..128 are zero.
- R6: In the forms 2'b01 and 2'b10, an in_spec value other than 4'b1111 gives out_ud=1 and out_wen=0 for that operation. The value 4'b1111 gives out_ud=0 and out_wen=1. When out_ud=1, out_data is not specified.
- R7: The form code 2'b11 is reserved and always gives out_ud=1 and out_wen=0.
- R8: A zero source element gives an all-zero lane (+0.0, never -0.0). -2^31 gives 64'hC1E0000000000000, 1 gives 64'h3FF0000000000000, and -1 gives 64'hBFF0000000000000.
- R9: out_data, out_wen and out_ud belong to the operation accepted on the previous rising edge with in_valid=1. out_valid is 1 exactly in the cycle after an accepted operation. A synchronous active-low reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| in_form | input | 2 | 00 legacy 128, 01 extended 128, 10 extended 256, 11 reserved |
| in_src | input | 128 | Four packed signed 32-bit integers |
| in_old_dst | input | 256 | Previous destination value, used for the kept upper half |
| in_spec | input | 4 | Spare register-specifier field, must be 1111 in extended forms |
| out_valid | output | 1 | Registered outputs hold a result |
| out_data | output | 256 | Four packed double-precision results |
| out_wen | output | 1 | Destination write permitted |
| out_ud | output | 1 | Undefined-opcode flag |

## Verification
A wrong leading-zero count or a bad magnitude corrupts the exponent and fraction of the affected lane. That error shows up in out_data one cycle after the operation, most plainly for -2^31, 1 and values near powers of two. A decode state that mixes up the forms shows up in the same cycle as a wrong upper half (kept, zeroed or converted) or as a wrong out_ud/out_wen pair. A stale or lost valid bit shows as an out_valid that does not match the accepted operation of the previous cycle.

// File: rtl/i2f_pkg.sv
// Shared constants and the form encoding for the packed int-to-double unit.
// Assumes the double-precision layout: 1 sign, 11 exponent, 52 fraction bits.
package i2f_pkg;
    typedef enum logic [1:0] {
        FORM_LEG128 = 2'b00,
        FORM_EXT128 = 2'b01,
        FORM_EXT256 = 2'b10,
        FORM_RSVD   = 2'b11
    } form_e;

    localparam int F64_W    = 64;
    localparam int EXP_W    = 11;
    localparam int FRAC_W   = 52;
    localparam int EXP_BIAS = 1023;
    localparam logic [3:0] SPEC_OK = 4'b1111;
endpackage

// File: rtl/i2f_lzc.sv
// Leading-zero counter for a W-bit vector.
// Returns W for an all-zero vector; purely combinational.
module i2f_lzc #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // Scan upward; the highest set bit found last sets the count.
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/i2f_lane.sv
// One lane: signed INT_W-bit integer to exact double-precision value.
// Assumes INT_W <= 53 so no rounding is ever needed; zero gives +0.0.
module i2f_lane
    import i2f_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic [INT_W-1:0] ival,
    output logic [F64_W-1:0] dval
);
    localparam int CW  = $clog2(INT_W + 1);
    localparam int PAD = FRAC_W - (INT_W - 1);

    logic             sgn;
    logic [INT_W-1:0] mag;
    logic [INT_W-1:0] norm;
    logic [CW-1:0]    lz;
    logic [EXP_W-1:0] bexp;

    // Sign and magnitude; the most negative value wraps to its own magnitude.
    assign sgn  = ival[INT_W-1];
    assign mag  = sgn ? (~ival + 1'b1) : ival;

    i2f_lzc #(.W(INT_W), .CW(CW)) u_lzc (
        .vec (mag),
        .cnt (lz)
    );

    // Normalise so the hidden bit lands at the top; derive the exponent.
    assign norm = mag << lz;
    assign bexp = EXP_W'(EXP_BIAS + INT_W - 1) - EXP_W'(lz);

    // Pack the fields, forcing an exact +0.0 for a zero input.
    always_comb begin
        if (mag == '0) dval = '0;
        else           dval = {sgn, bexp, norm[INT_W-2:0], {PAD{1'b0}}};
    end
endmodule

// File: rtl/i2f_form_dec.sv
// Decodes the form code and checks the spare specifier field.
// Assumes the legacy form ignores the spare field entirely.
module i2f_form_dec
    import i2f_pkg::*;
(
    input  logic [1:0] form,
    input  logic [3:0] spec,
    output logic       conv_upper,
    output logic       keep_upper,
    output logic       bad_op
);
    // Map the form code onto upper-half policy and legality.
    always_comb begin
        conv_upper = (form == FORM_EXT256);
        keep_upper = (form == FORM_LEG128);
        bad_op     = (form == FORM_RSVD) ||
                     ((form != FORM_LEG128) && (spec != SPEC_OK));
    end
endmodule

// File: rtl/pk_i2f64_conv.sv
// Packed signed-integer to double-precision converter with one register stage.
// Lower half lanes always convert; upper lanes convert, keep the old
// destination, or clear, depending on the form. Assumes LANES is even.
module pk_i2f64_conv
    import i2f_pkg::*;
#(
    parameter int INT_W = 32,
    parameter int LANES = 4,
    parameter int SRC_W = INT_W * LANES,
    parameter int DST_W = F64_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_form,
    input  logic [SRC_W-1:0] in_src,
    input  logic [DST_W-1:0] in_old_dst,
    input  logic [3:0]       in_spec,
    output logic             out_valid,
    output logic [DST_W-1:0] out_data,
    output logic             out_wen,
    output logic             out_ud
);
    localparam int NARROW = LANES / 2;

    logic             conv_upper;
    logic             keep_upper;
    logic             bad_op;
    logic [DST_W-1:0] nxt_data;

    i2f_form_dec u_dec (
        .form       (in_form),
        .spec       (in_spec),
        .conv_upper (conv_upper),
        .keep_upper (keep_upper),
        .bad_op     (bad_op)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [F64_W-1:0] res;

        i2f_lane #(.INT_W(INT_W)) u_lane (
            .ival (in_src[g*INT_W +: INT_W]),
            .dval (res)
        );

        if (g < NARROW) begin : g_low
            // Lower lanes are converted in every form.
            assign nxt_data[g*F64_W +: F64_W] = res;
        end else begin : g_high
            // Upper lanes follow the form's policy.
            assign nxt_data[g*F64_W +: F64_W] =
                conv_upper ? res :
                keep_upper ? in_old_dst[g*F64_W +: F64_W] : '0;
        end
    end

    // Output stage: capture result and flags on an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_wen   <= 1'b0;
            out_ud    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= nxt_data;
                out_wen  <= !bad_op;
                out_ud   <= bad_op;
            end
        end
    end
endmodule

// File: rtl/pk_i2f64_conv_chk.sv
// Property checker for pk_i2f64_conv, bound to every instance.
// Assumes the default lane layout: 64-bit result lanes, 32-bit source lanes.
module pk_i2f64_conv_chk #(
    parameter int INT_W = 32,
    parameter int LANES = 4,
    parameter int SRC_W = INT_W * LANES,
    parameter int DST_W = 64 * LANES
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       in_form,
    input logic [SRC_W-1:0] in_src,
    input logic [DST_W-1:0] in_old_dst,
    input logic [3:0]       in_spec,
    input logic             out_valid,
    input logic [DST_W-1:0] out_data,
    input logic             out_wen,
    input logic             out_ud
);
    localparam int HALF = DST_W / 2;

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_wen != out_ud));
    p_bad_spec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_form != 2'b00) && (in_spec != 4'b1111)) |=> (out_ud && !out_wen));
    p_rsvd_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_form == 2'b11)) |=> out_ud);
    p_keep_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_form == 2'b00)) |=>
        (out_wen && (out_data[DST_W-1:HALF] == $past(in_old_dst[DST_W-1:HALF]))));
    p_zero_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_form == 2'b01)) |=> (out_data[DST_W-1:HALF] == '0));
    p_lane0_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_form != 2'b11) && (in_spec == 4'b1111)) |=>
        (out_data[63] == $past(in_src[INT_W-1])));
    p_top_lane_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_form == 2'b10) && (in_spec == 4'b1111)) |=>
        (out_data[DST_W-1] == $past(in_src[SRC_W-1])));
    p_zero_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_form != 2'b11) && (in_spec == 4'b1111) && (in_src[INT_W-1:0] == '0))
        |=> (out_data[63:0] == '0));
endmodule

bind pk_i2f64_conv pk_i2f64_conv_chk #(
    .INT_W (INT_W),
    .LANES (LANES),
    .SRC_W (SRC_W),
    .DST_W (DST_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_form    (in_form),
    .in_src     (in_src),
    .in_old_dst (in_old_dst),
    .in_spec    (in_spec),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_wen    (out_wen),
    .out_ud     (out_ud)
);

// File: tb/tb_pk_i2f64_conv.sv
// Bench: behavioural reference (real-number conversion) compared every clock.
module tb_pk_i2f64_conv;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   in_form = 2'b00;
    logic [127:0] in_src = '0;
    logic [255:0] in_old_dst = '0;
    logic [3:0]   in_spec = 4'hF;
    logic         out_valid;
    logic [255:0] out_data;
    logic         out_wen;
    logic         out_ud;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic         e_valid = 0;
    logic [255:0] e_data = '0;
    logic         e_ud = 0;
    logic [1:0]   e_form = 0;
    string        e_tag = "R1";

    always #2 clk = ~clk;

    pk_i2f64_conv dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_form(in_form),
        .in_src(in_src), .in_old_dst(in_old_dst), .in_spec(in_spec),
        .out_valid(out_valid), .out_data(out_data), .out_wen(out_wen), .out_ud(out_ud)
    );

    function automatic logic [63:0] ref_f64(input logic [31:0] x);
        real r;
        r = real'(int'($signed(x)));
        if (x == 32'd0) return 64'd0;
        return $realtobits(r);
    endfunction

    task automatic check_eq(string tag, string what, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare outputs against the expectation for the previous cycle.
    task automatic compare();
        string hi_tag;
        check_eq("R9", "out_valid", 256'(out_valid), 256'(e_valid));
        if (e_valid) begin
            check_eq(e_form == 2'b11 ? "R7" : "R6", "out_ud", 256'(out_ud), 256'(e_ud));
            check_eq(e_form == 2'b11 ? "R7" : "R6", "out_wen", 256'(out_wen), 256'(!e_ud));
            if (!e_ud) begin
                hi_tag = (e_form == 2'b00) ? "R4" : (e_form == 2'b01) ? "R5" : "R3";
                check_eq(e_tag, "lanes 1..0", 256'(out_data[127:0]), 256'(e_data[127:0]));
                check_eq(hi_tag, "lanes 3..2", 256'(out_data[255:128]), 256'(e_data[255:128]));
            end
        end
    endtask

    task automatic step(logic v, logic [1:0] f, logic [127:0] s, logic [255:0] o,
                        logic [3:0] sp, string tag);
        @(negedge clk);
        compare();
        in_valid = v; in_form = f; in_src = s; in_old_dst = o; in_spec = sp;
        e_valid = v; e_form = f; e_tag = tag;
        e_ud = (f == 2'b11) || ((f != 2'b00) && (sp != 4'hF));
        e_data[63:0]   = ref_f64(s[31:0]);
        e_data[127:64] = ref_f64(s[63:32]);
        case (f)
            2'b00:   e_data[255:128] = o[255:128];
            2'b01:   e_data[255:128] = '0;
            default: begin
                e_data[191:128] = ref_f64(s[95:64]);
                e_data[255:192] = ref_f64(s[127:96]);
            end
        endcase
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R9", "out_valid in reset", 256'(out_valid), 256'(0));
        rst_n = 1'b1;

        // R8 reference points, lane-wise.
        step(1, 2'b10, {32'd0, 32'h8000_0000, 32'd1, 32'hFFFF_FFFF}, '0, 4'hF, "R8");
        step(1, 2'b01, {64'hFFFF_FFFF_FFFF_FFFF, 32'd0, 32'h8000_0000}, '1, 4'hF, "R8");
        // R1 extremes and powers of two.
        step(1, 2'b10, {32'h7FFF_FFFF, 32'h4000_0000, 32'h0000_0003, 32'h8000_0001}, '0, 4'hF, "R1");
        step(1, 2'b00, {rnd128()}, {rnd128(), rnd128()}, 4'h0, "R4");
        // R2: upper source bits vary but must not matter.
        step(1, 2'b01, {64'hDEAD_BEEF_1234_5678, 32'd5, 32'hFFFF_FFF0}, '0, 4'hF, "R2");
        step(1, 2'b01, {64'h0, 32'd5, 32'hFFFF_FFF0}, '1, 4'hF, "R2");
        step(1, 2'b00, {64'hFFFF_0000_FFFF_0000, 32'd7, 32'd9}, {rnd128(), rnd128()}, 4'hF, "R2");
        // R6 / R7 illegal encodings, then a gap and back-to-back.
        step(1, 2'b01, rnd128(), '0, 4'hE, "R6");
        step(1, 2'b10, rnd128(), '0, 4'h7, "R6");
        step(1, 2'b11, rnd128(), '0, 4'hF, "R7");
        step(0, 2'b10, rnd128(), '0, 4'hF, "R9");
        step(0, 2'b00, rnd128(), '0, 4'hF, "R9");
        step(1, 2'b10, rnd128(), '0, 4'hF, "R3");

        for (int i = 0; i < 400; i++) begin
            logic [1:0] f;
            logic [3:0] sp;
            f  = 2'($urandom_range(0, 3));
            sp = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
            step(1'($urandom_range(0, 4) != 0), f, rnd128(), {rnd128(), rnd128()}, sp, "R1");
        end

        // Reset mid-stream clears out_valid.
        step(1, 2'b10, rnd128(), '0, 4'hF, "R3");
        @(negedge clk);
        compare();
        rst_n = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check_eq("R9", "out_valid after reset", 256'(out_valid), 256'(0));
        in_valid = 1'b0; rst_n = 1'b1; e_valid = 0;
        step(0, 2'b00, '0, '0, 4'hF, "R9");
        step(0, 2'b00, '0, '0, 4'hF, "R9");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule